// File: doc/BRIEF.md
# Rectangle Copy Engine

This block moves a rectangular group of pixels from one place in a frame buffer to another. The frame buffer lives in a shared memory that is 16 bits wide. Software sets up the job through an 8-bit register bus: source and destination byte addresses, rectangle size, line pitch, pixel depth and direction. It then sets the go bit. The engine reads pixels through a request/acknowledge memory port into a 16-word FIFO and writes them back out. It works in batches of up to 16 pixels, and the go bit reads as 1 until the last pixel has been written.

When the two regions overlap and the destination lies later in memory than the source, software selects the backward operation. Both start addresses then point at the last (bottom-right) pixel, and the engine walks toward lower addresses. The forward operation starts at the top-left pixel and walks toward higher addresses. At 8 bits per pixel, each byte is written through a single byte enable, so the neighbouring byte in the same word is never touched.

Top module: `rect_move_engine`

## Requirements
- R1: The register map uses these offsets. Offset 0 is control/status. Offset 1 holds pixel depth in bit 0. Offset 2 holds the operation code. Offsets 3..5 hold the source byte address and offsets 6..8 the destination byte address, each least significant byte first. Offsets 9/10 hold width-1 (low/high) and offsets 11/12 hold height-1 (low/high). Offset 13 holds the pitch low byte and offset 14 its upper 4 bits. Every register reads back what was written. Offset 14 reads its unused upper bits as 0.
- R2: Writing offset 0 with bit 7 set while idle starts a job. Offset 0 bit 7 then reads 1 and clears by itself once the final destination write has been acknowledged.
- R3: Operation code 0x02 copies forward. Pixel (c,r) of the source, counted from the top-left start address, lands at the same (c,r) of the destination.
- R4: Operation code 0x03 copies backward from the last pixel toward lower addresses. An overlapping copy whose destination follows its source gives the same result as a copy made from an untouched snapshot.
- R5: Depth bit 1 selects 16 bpp (2-byte pixels, byte enable 2'b11). Depth bit 0 selects 8 bpp. At 8 bpp an even byte address uses byte enable 2'b01 with data in bits 7:0, and an odd address uses 2'b10 with bits 15:8.
- R6: The pitch is counted in 16-bit words. Consecutive rows are 2*pitch bytes apart.
- R7: A rectangle whose width-1 and height-1 registers are both 0 performs exactly one memory write before bit 7 clears.
- R8: While a job runs, register writes are ignored, including a second go. Reads still work.
- R9: Offset 0 reports the FIFO state on three bits. Bit 4 means empty. Bit 6 means full (16 words). Bit 5 means between half and one below full (8..15 words). No two of these bits are ever set together.
- R10: After reset every register reads 0, except offset 0, which reads 0x10 (FIFO empty). No memory request is raised.
- R11: A memory request keeps its address, direction and data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 23 | 16-bit word address (byte address bits 23:1) |
| mem_be | output | 2 | Byte enables |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 16 | Read data |

## Verification
Register read data is registered, so a value is due one clock after its offset is presented. The bench drives the offset just after a falling edge and samples at the following falling edge. A go write shows up in offset 0 bit 7 on the very next read, and the bench polls offset 0 on every cycle afterwards. Because of this, the single cycle in which the FIFO holds 16 words is seen, and so is the exact read on which bit 7 drops. Memory contents, write counts and byte enables are compared only after bit 7 has cleared, against a copy computed in the bench from a snapshot of memory taken before the go write.

// File: rtl/rme_pkg.sv
package rme_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;

  // register offsets
  localparam int OFF_CTRL  = 0;
  localparam int OFF_DEPTH = 1;
  localparam int OFF_OP    = 2;
  localparam int OFF_SRC   = 3;
  localparam int OFF_DST   = OFF_SRC + ADDR_BYTES;
  localparam int OFF_WID   = OFF_DST + ADDR_BYTES;
  localparam int OFF_HGT   = OFF_WID + 2;
  localparam int OFF_PITCH = OFF_HGT + 2;

  // control/status bits
  localparam int BIT_GO    = 7;
  localparam int BIT_FULL  = 6;
  localparam int BIT_HALF  = 5;
  localparam int BIT_EMPTY = 4;

  localparam logic [7:0] OPC_BACKWARD = 8'h03;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_FETCH, ST_WRITE} eng_state_t;
endpackage

// File: rtl/rme_regs.sv
module rme_regs
  import rme_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int PITCH_W = 12,
  parameter int REG_AW  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               busy,
  input  logic               st_full,
  input  logic               st_half,
  input  logic               st_empty,
  output logic [7:0]         rd_value,
  output logic               start,
  output logic               bpp16,
  output logic               backward,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [DIM_W-1:0]   width_m1,
  output logic [DIM_W-1:0]   height_m1,
  output logic [PITCH_W-1:0] pitch_words
);
  localparam int PHI_W = PITCH_W - 8;

  logic       wr_ok;
  logic [7:0] op_q;
  logic [15:0] wid_q, hgt_q;

  assign wr_ok    = we && !busy;
  assign start    = wr_ok && (addr == REG_AW'(OFF_CTRL)) && wdata[BIT_GO];
  assign backward = (op_q == OPC_BACKWARD);
  assign width_m1  = wid_q[DIM_W-1:0];
  assign height_m1 = hgt_q[DIM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bpp16       <= 1'b0;
      op_q        <= '0;
      src_addr    <= '0;
      dst_addr    <= '0;
      wid_q       <= '0;
      hgt_q       <= '0;
      pitch_words <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (addr == REG_AW'(OFF_SRC + i)) src_addr[8*i +: 8] <= wdata;
        if (addr == REG_AW'(OFF_DST + i)) dst_addr[8*i +: 8] <= wdata;
      end
      for (int i = 0; i < 2; i++) begin
        if (addr == REG_AW'(OFF_WID + i)) wid_q[8*i +: 8] <= wdata;
        if (addr == REG_AW'(OFF_HGT + i)) hgt_q[8*i +: 8] <= wdata;
      end
      if (addr == REG_AW'(OFF_DEPTH))     bpp16 <= wdata[0];
      if (addr == REG_AW'(OFF_OP))        op_q  <= wdata;
      if (addr == REG_AW'(OFF_PITCH))     pitch_words[7:0] <= wdata;
      if (addr == REG_AW'(OFF_PITCH + 1)) pitch_words[PITCH_W-1:8] <= wdata[PHI_W-1:0];
    end
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (addr == REG_AW'(OFF_SRC + i)) rd_value = src_addr[8*i +: 8];
      if (addr == REG_AW'(OFF_DST + i)) rd_value = dst_addr[8*i +: 8];
    end
    for (int i = 0; i < 2; i++) begin
      if (addr == REG_AW'(OFF_WID + i)) rd_value = wid_q[8*i +: 8];
      if (addr == REG_AW'(OFF_HGT + i)) rd_value = hgt_q[8*i +: 8];
    end
    if (addr == REG_AW'(OFF_CTRL)) begin
      rd_value[BIT_GO]    = busy;
      rd_value[BIT_FULL]  = st_full;
      rd_value[BIT_HALF]  = st_half;
      rd_value[BIT_EMPTY] = st_empty;
    end
    if (addr == REG_AW'(OFF_DEPTH))     rd_value = {7'b0, bpp16};
    if (addr == REG_AW'(OFF_OP))        rd_value = op_q;
    if (addr == REG_AW'(OFF_PITCH))     rd_value = pitch_words[7:0];
    if (addr == REG_AW'(OFF_PITCH + 1)) rd_value = 8'(pitch_words[PITCH_W-1:8]);
  end

  // writes during a job leave the programmed job untouched
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && we) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(wid_q)
                      && $stable(hgt_q) && $stable(op_q) && $stable(pitch_words)));
endmodule

// File: rtl/rme_fifo.sv
module rme_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             half,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign half  = (count >= CNT_W'(DEPTH/2)) && !full;

  // storage without reset, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
    if (pop)  pop_data  <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({full, half, empty}));
endmodule

// File: rtl/rme_walker.sv
module rme_walker
  import rme_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [DIM_W-1:0]   width_m1,
  input  logic [DIM_W-1:0]   height_m1,
  input  logic [PITCH_W-1:0] pitch_words,
  input  logic               bpp16,
  input  logic               backward,
  input  logic               advance,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic               last,
  output logic               finished
);
  logic [ADDR_W-1:0] row_start, stride, pix_step, next_row;
  logic [DIM_W-1:0]  col, row;

  assign stride   = {{(ADDR_W-PITCH_W-1){1'b0}}, pitch_words, 1'b0};
  assign pix_step = bpp16 ? ADDR_W'(2) : ADDR_W'(1);
  assign next_row = backward ? row_start - stride : row_start + stride;
  assign last     = (col == width_m1) && (row == height_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      row_start <= '0;
      col       <= '0;
      row       <= '0;
      finished  <= 1'b1;
    end else if (load) begin
      cur_addr  <= start_addr;
      row_start <= start_addr;
      col       <= '0;
      row       <= '0;
      finished  <= 1'b0;
    end else if (advance) begin
      if (last) begin
        finished <= 1'b1;
      end else if (col == width_m1) begin
        col       <= '0;
        row       <= row + 1'b1;
        row_start <= next_row;
        cur_addr  <= next_row;
      end else begin
        col      <= col + 1'b1;
        cur_addr <= backward ? cur_addr - pix_step : cur_addr + pix_step;
      end
    end
  end

  // the sequencer never steps a walker past its final pixel
  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    advance |-> !finished);
endmodule

// File: rtl/rect_move_engine.sv
module rect_move_engine
  import rme_pkg::*;
#(
  parameter int DIM_W      = 16,
  parameter int PITCH_W    = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int REG_AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int N_WALK = 2;  // 0: source, 1: destination

  eng_state_t state;
  logic busy, start, bpp16, backward;
  logic [7:0] rd_value;
  logic [ADDR_W-1:0]  src_addr, dst_addr, sel_addr;
  logic [DIM_W-1:0]   width_m1, height_m1;
  logic [PITCH_W-1:0] pitch_words;
  logic fifo_push, fifo_pop, fifo_full, fifo_half, fifo_empty;
  logic [15:0] fifo_in, fifo_out;
  logic [CNT_W-1:0] fifo_count;
  logic [7:0] rd_byte;

  logic [ADDR_W-1:0] w_start [N_WALK];
  logic [ADDR_W-1:0] w_cur   [N_WALK];
  logic              w_adv   [N_WALK];
  logic              w_last  [N_WALK];
  logic              w_fin   [N_WALK];

  assign busy = (state != ST_IDLE);

  rme_regs #(.DIM_W(DIM_W), .PITCH_W(PITCH_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .st_full(fifo_full), .st_half(fifo_half), .st_empty(fifo_empty),
    .rd_value(rd_value), .start(start), .bpp16(bpp16), .backward(backward),
    .src_addr(src_addr), .dst_addr(dst_addr), .width_m1(width_m1),
    .height_m1(height_m1), .pitch_words(pitch_words)
  );

  always_comb begin
    w_start[0] = src_addr;
    w_start[1] = dst_addr;
    w_adv[0]   = (state == ST_READ)  && mem_ack;
    w_adv[1]   = (state == ST_WRITE) && mem_ack;
  end

  for (genvar g = 0; g < N_WALK; g++) begin : g_walk
    rme_walker #(.DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_walk (
      .clk(clk), .rst(rst), .load(start), .start_addr(w_start[g]),
      .width_m1(width_m1), .height_m1(height_m1), .pitch_words(pitch_words),
      .bpp16(bpp16), .backward(backward), .advance(w_adv[g]),
      .cur_addr(w_cur[g]), .last(w_last[g]), .finished(w_fin[g])
    );
  end

  assign rd_byte   = w_cur[0][0] ? mem_rdata[15:8] : mem_rdata[7:0];
  assign fifo_in   = bpp16 ? mem_rdata : {8'h00, rd_byte};
  assign fifo_push = w_adv[0];
  assign fifo_pop  = (state == ST_FETCH);

  rme_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .push_data(fifo_in),
    .pop(fifo_pop), .pop_data(fifo_out), .count(fifo_count),
    .full(fifo_full), .half(fifo_half), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_value;
      case (state)
        ST_IDLE:  if (start) state <= ST_READ;
        ST_READ:  if (mem_ack)
                    state <= (w_last[0] || fifo_count == CNT_W'(FIFO_DEPTH-1))
                             ? ST_FETCH : ST_READ;
        ST_FETCH: state <= ST_WRITE;
        ST_WRITE: if (mem_ack) begin
                    if (w_last[1])      state <= ST_IDLE;
                    else if (fifo_empty) state <= ST_READ;
                    else                 state <= ST_FETCH;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign sel_addr  = (state == ST_WRITE) ? w_cur[1] : w_cur[0];
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = sel_addr[ADDR_W-1:1];
  assign mem_be    = !mem_req ? 2'b00 : bpp16 ? 2'b11 : (sel_addr[0] ? 2'b10 : 2'b01);
  assign mem_wdata = bpp16 ? fifo_out : {fifo_out[7:0], fifo_out[7:0]};

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));
  assert_go_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  assert_busy_ends_on_last_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(w_last[1] && mem_ack));
  assert_single_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !bpp16) |-> ($countones(mem_be) == 1));
  assert_src_first_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !w_fin[1]);
endmodule

// File: tb/sim_rect_move_engine.sv
module sim_rect_move_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mem_req, mem_we;
  logic [22:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  rect_move_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [7:0] mb [0:4095];
  logic [7:0] ex [0:4095];
  int n_chk = 0, n_fail = 0, wr_count = 0;
  logic [1:0] last_be = 2'b00;

  // memory responder: random wait, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && ($urandom % 3 != 0)) begin
        int wa;
        wa = {mem_addr[10:0], 1'b0};
        if (mem_we) begin
          if (mem_be[0]) mb[wa]   = mem_wdata[7:0];
          if (mem_be[1]) mb[wa+1] = mem_wdata[15:8];
          wr_count++;
          last_be = mem_be;
        end else mem_rdata = {mb[wa+1], mb[wa]};
        mem_ack = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 5'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    reg_addr = 5'(a);
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic int paddr(input int x, input int y, input int bp, input int stride);
    return y * stride + x * bp;
  endfunction

  bit saw_full, saw_half, saw_clash;

  // runs one copy; inject=1 also tries register writes while busy
  task automatic run_copy(input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input bit b16, input int pw,
                          input bit inject, input string tag);
    int bp, stride, src, dst, polls;
    bit back;
    logic [7:0] v;
    logic [7:0] sn [0:4095];
    bp = b16 ? 2 : 1;
    stride = 2 * pw;
    back = (dy > sy) || (dy == sy && dx >= sx);
    if (back) begin
      src = paddr(sx + w - 1, sy + h - 1, bp, stride);
      dst = paddr(dx + w - 1, dy + h - 1, bp, stride);
    end else begin
      src = paddr(sx, sy, bp, stride);
      dst = paddr(dx, dy, bp, stride);
    end
    for (int i = 0; i < 4096; i++) begin sn[i] = mb[i]; ex[i] = mb[i]; end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        for (int b = 0; b < bp; b++)
          ex[paddr(dx + c, dy + r, bp, stride) + b] = sn[paddr(sx + c, sy + r, bp, stride) + b];
    wr(1, b16); wr(2, back ? 3 : 2);
    for (int i = 0; i < 3; i++) begin wr(3 + i, src >> (8*i)); wr(6 + i, dst >> (8*i)); end
    wr(9, (w-1) & 255); wr(10, (w-1) >> 8);
    wr(11, (h-1) & 255); wr(12, (h-1) >> 8);
    wr(13, pw & 255); wr(14, pw >> 8);
    wr(0, 0);
    wr_count = 0;
    wr(0, 8'h80);
    rd(0, v);
    chk(v[7] == 1'b1, {tag, " R2 busy after go"}, v, 8'h80);
    if (inject) begin
      wr(9, 8'h77);
      wr(0, 8'h80);
      wr(3, 8'h55);
    end
    polls = 0;
    while (v[7] && polls < 20000) begin
      rd(0, v);
      if (v[6]) saw_full = 1;
      if (v[5]) saw_half = 1;
      if ($countones(v[6:4]) > 1) saw_clash = 1;
      polls++;
    end
    chk(v[7] == 1'b0, {tag, " R2 busy self-clears"}, v, 0);
    chk(v == 8'h10, {tag, " R9 idle status empty"}, v, 8'h10);
    begin
      int mism = 0;
      for (int i = 0; i < 4096; i++) if (mb[i] !== ex[i]) mism++;
      chk(mism == 0, {tag, " R3 R4 R6 memory image"}, mism, 0);
    end
    chk(wr_count == w * h, {tag, " R7 write count"}, wr_count, w * h);
    if (inject) begin
      rd(9, v);
      chk(v == 8'((w-1) & 255), {tag, " R8 width kept"}, v, (w-1) & 255);
      rd(3, v);
      chk(v == 8'(src & 255), {tag, " R8 source kept"}, v, src & 255);
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    for (int i = 0; i < 4096; i++) mb[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk(mem_req == 1'b0, "R10 no request", mem_req, 0);
    rd(0, v);  chk(v == 8'h10, "R10 status", v, 8'h10);
    for (int a = 1; a < 15; a++) begin
      rd(a, v); chk(v == 8'h00, "R10 register zero", v, 0);
    end

    // R1 read back
    wr(3, 8'h12); wr(4, 8'h34); wr(5, 8'h56);
    rd(3, v); chk(v == 8'h12, "R1 src byte0", v, 8'h12);
    rd(5, v); chk(v == 8'h56, "R1 src byte2", v, 8'h56);
    wr(14, 8'hFF); rd(14, v); chk(v == 8'h0F, "R1 pitch high", v, 8'h0F);
    wr(2, 8'h02);  rd(2, v);  chk(v == 8'h02, "R1 opcode", v, 8'h02);

    run_copy(2, 2, 20, 10, 5, 3, 1, 32, 0, "R3 fwd16");
    run_copy(3, 4, 5, 5, 6, 4, 1, 32, 0, "R4 back16");
    run_copy(4, 7, 5, 7, 7, 2, 0, 32, 0, "R4 back8 same row");
    run_copy(6, 6, 4, 5, 5, 4, 0, 32, 0, "R3 fwd overlap8");
    run_copy(1, 1, 9, 9, 1, 1, 1, 32, 0, "R7 one pixel");
    run_copy(2, 3, 7, 12, 1, 1, 0, 32, 0, "R5 odd");
    chk(last_be == 2'b10, "R5 odd byte lane", last_be, 2'b10);
    run_copy(3, 3, 10, 14, 1, 1, 0, 32, 0, "R5 even");
    chk(last_be == 2'b01, "R5 even byte lane", last_be, 2'b01);
    run_copy(0, 0, 3, 12, 8, 5, 1, 20, 0, "R6 pitch20");
    saw_full = 0; saw_half = 0; saw_clash = 0;
    run_copy(0, 0, 14, 8, 12, 6, 1, 32, 1, "R8 busy writes");
    chk(saw_full, "R9 full seen", saw_full, 1);
    chk(saw_half, "R9 half seen", saw_half, 1);
    chk(!saw_clash, "R9 flags exclusive", saw_clash, 0);

    for (int n = 0; n < 20; n++) begin
      bit b16;
      int pw, bp, xres, w, h, sx, sy, dx, dy;
      b16 = 1'($urandom % 2);
      pw = (n % 3 == 0) ? 16 : (n % 3 == 1) ? 24 : 32;
      bp = b16 ? 2 : 1;
      xres = 2 * pw / bp;
      w = 1 + int'($urandom % 8);
      h = 1 + int'($urandom % 6);
      sx = int'($urandom % (xres - w + 1));
      sy = int'($urandom % (32 - h + 1));
      if (n % 2 == 0) begin
        dx = sx + int'($urandom % 7) - 3;
        dy = sy + int'($urandom % 5) - 2;
        if (dx < 0) dx = 0;
        if (dx > xres - w) dx = xres - w;
        if (dy < 0) dy = 0;
        if (dy > 32 - h) dy = 32 - h;
      end else begin
        dx = int'($urandom % (xres - w + 1));
        dy = int'($urandom % (32 - h + 1));
      end
      run_copy(sx, sy, dx, dy, w, h, b16, pw, 0, "R3 R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule